// File: doc/BRIEF.md
# Dual-FIFO Programmable Flag Router

This block derives the status flags of a two-direction FIFO pair. One direction carries words from side A to side B, the other carries them from side B to side A. For each direction it takes the occupancy count of that array and produces four flags: Empty, Almost-Empty, Full and Almost-Full. The two Almost thresholds of each direction are offsets that software writes through a small configuration port.

All eight flags are shown together on a status output. A routing word lets software place any one of the eight flags on each of four shared flag pins. The FIFO storage, the pointers and the data path sit outside the block and supply the two occupancy counts.

No data stream passes through the block, so it has no valid/ready handshake. Configuration writes are single-cycle strobes that are always accepted, and the block never applies back-pressure.

Top module: `dual_fifo_flag_router`

## Requirements
- R1: While reset is held and straight after it, every offset is 0, the routing word is 0x3210, both Empty flags are 1 and both Full flags are 0.
- R2: The Empty flag of a direction is registered. It is 1 in the cycle after a clock edge at which that direction's count was 0, and 0 in the cycle after a clock edge at which the count was non-zero.
- R3: The Almost-Empty flag of a direction is combinational. It is 1 exactly when the current count is less than or equal to that direction's Almost-Empty offset.
- R4: The Almost-Full flag of a direction is combinational. It is 1 exactly when the free space (DEPTH minus the current count) is less than or equal to that direction's Almost-Full offset.
- R5: The Full flag of a direction is registered. It is 1 in the cycle after a clock edge at which the count equalled DEPTH, and 0 otherwise.
- R6: A write to address 0, 1, 2 or 3 loads the A-to-B Almost-Empty, A-to-B Almost-Full, B-to-A Almost-Empty or B-to-A Almost-Full offset respectively. The write takes data bits OFS_W-1:0 and ignores the upper data bits. The new offset governs the flags from the cycle after the write.
- R7: A write to address 4 loads the routing word. Flag pin p (p = 0..3, where pin 0 is pin A) shows the status bit whose index is given by bits 4p+2:4p of the routing word. Bit 4p+3 is ignored.
- R8: Status bits 0..3 carry the A-to-B Empty, Almost-Empty, Full and Almost-Full flags. Bits 4..7 carry the same four flags for B-to-A.
- R9: A pulse on sw_clear_all clears all four offsets at the next edge. It leaves the routing word unchanged, and it takes priority over a write in the same cycle.
- R10: Writes to addresses 5, 6 and 7 change neither the offsets nor the routing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_clear_all | input | 1 | Software clear of all Almost offsets |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| ab_count | input | CNT_W | A-to-B occupancy (0..DEPTH) |
| ba_count | input | CNT_W | B-to-A occupancy (0..DEPTH) |
| flag_status | output | 8 | All eight flags, ordered as in R8 |
| flag_pin | output | 4 | Routed flag pins, bit 0 is pin A |

## Verification
The bench builds the block with DEPTH = 16 and keeps OFS_W at 10. With the shallow depth, random counts reach both 0 and full often, so the registered Empty and Full flags get exercised through their one-cycle lag. Random offsets run a few entries past the depth, which covers both the threshold boundaries and the cases where an Almost flag is always on. The wide offset field together with junk in the upper data bits checks that the upper bits are dropped.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int NUM_DIRS      = 2;
  localparam int FLAGS_PER_DIR = 4;
  localparam int NUM_FLAGS     = NUM_DIRS * FLAGS_PER_DIR;
  localparam int NUM_PINS      = 4;
  localparam int CODE_W        = 4;
  localparam int SEL_W         = $clog2(NUM_FLAGS);
  localparam int CFG_DW        = 16;
  localparam int CFG_AW        = 3;
  localparam int NUM_OFS       = 4;

  typedef enum logic [1:0] {
    FL_EMPTY  = 2'd0,
    FL_AEMPTY = 2'd1,
    FL_FULL   = 2'd2,
    FL_AFULL  = 2'd3
  } flag_pos_e;

  localparam logic [CFG_AW-1:0] ADDR_ROUTE = 3'd4;
  localparam logic [CFG_DW-1:0] ROUTE_RST  = 16'h3210;
endpackage

// File: rtl/dfr_cfg_regs.sv
module dfr_cfg_regs
  import dfr_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sw_clear,
  input  logic                           we,
  input  logic [CFG_AW-1:0]              addr,
  input  logic [CFG_DW-1:0]              wdata,
  output logic [NUM_OFS-1:0][OFS_W-1:0]  ofs,
  output logic [CFG_DW-1:0]              route
);
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q;
  logic [CFG_DW-1:0]             route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (sw_clear) begin
      ofs_q <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_OFS; i++) begin
        if (addr == CFG_AW'(i)) ofs_q[i] <= wdata[OFS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          route_q <= ROUTE_RST;
    else if (we && addr == ADDR_ROUTE)   route_q <= wdata;
  end

  assign ofs   = ofs_q;
  assign route = route_q;

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (ofs_q == '0));

  // R7
  route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_ROUTE) |=> (route_q == $past(wdata)));
endmodule

// File: rtl/dfr_flag_calc.sv
module dfr_flag_calc
  import dfr_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10,
  parameter int OFS_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [OFS_W-1:0]         ae_ofs,
  input  logic [OFS_W-1:0]         af_ofs,
  output logic [FLAGS_PER_DIR-1:0] flags
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             empty_q, full_q;
  logic [CNT_W-1:0] free_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      empty_q <= (cnt == '0);
      full_q  <= (cnt == DEPTH_C);
    end
  end

  assign free_cnt = DEPTH_C - cnt;

  always_comb begin
    flags            = '0;
    flags[FL_EMPTY]  = empty_q;
    flags[FL_FULL]   = full_q;
    flags[FL_AEMPTY] = (32'(cnt) <= 32'(ae_ofs));
    flags[FL_AFULL]  = (32'(free_cnt) <= 32'(af_ofs));
  end

  // R2
  empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> empty_q);

  // R5
  full_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == DEPTH_C) |=> full_q);

  // R2
  no_empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_q && full_q));
endmodule

// File: rtl/dfr_pin_mux.sv
module dfr_pin_mux
  import dfr_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] status,
  input  logic [CFG_DW-1:0]    route,
  output logic [NUM_PINS-1:0]  pins
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] sel;
    assign sel     = route[p*CODE_W +: SEL_W];
    assign pins[p] = status[sel];
  end
endmodule

// File: rtl/dual_fifo_flag_router.sv
module dual_fifo_flag_router
  import dfr_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OFS_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_clear_all,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic [CNT_W-1:0]     ab_count,
  input  logic [CNT_W-1:0]     ba_count,
  output logic [NUM_FLAGS-1:0] flag_status,
  output logic [NUM_PINS-1:0]  flag_pin
);
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs;
  logic [CFG_DW-1:0]             route;
  logic [NUM_DIRS-1:0][CNT_W-1:0] counts;

  assign counts[0] = ab_count;
  assign counts[1] = ba_count;

  dfr_cfg_regs #(.OFS_W(OFS_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_clear (sw_clear_all),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .ofs      (ofs),
    .route    (route)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    dfr_flag_calc #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_calc (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (counts[d]),
      .ae_ofs (ofs[2*d]),
      .af_ofs (ofs[2*d+1]),
      .flags  (flag_status[d*FLAGS_PER_DIR +: FLAGS_PER_DIR])
    );
  end

  dfr_pin_mux u_mux (
    .status (flag_status),
    .route  (route),
    .pins   (flag_pin)
  );

  // R10
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > ADDR_ROUTE && !sw_clear_all) |=> $stable(route));
endmodule

// File: tb/test_dual_fifo_flag_router.sv
module test_dual_fifo_flag_router;
  localparam int DEPTH = 16;
  localparam int OFS_W = 10;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [CNT_W-1:0] cab = '0, cba = '0;
  logic [7:0] status;
  logic [3:0] pins;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_ofs [4];
  logic [15:0] m_route;
  bit m_eab, m_fab, m_eba, m_fba;

  always #4 clk = ~clk;

  dual_fifo_flag_router #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_dual_fifo_flag_router (
    .clk(clk), .rst_n(rst_n), .sw_clear_all(sw), .cfg_we(we),
    .cfg_addr(addr), .cfg_wdata(wdata), .ab_count(cab), .ba_count(cba),
    .flag_status(status), .flag_pin(pins)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s[0] = m_eab;
    s[1] = (int'(cab) <= m_ofs[0]);
    s[2] = m_fab;
    s[3] = ((DEPTH - int'(cab)) <= m_ofs[1]);
    s[4] = m_eba;
    s[5] = (int'(cba) <= m_ofs[2]);
    s[6] = m_fba;
    s[7] = ((DEPTH - int'(cba)) <= m_ofs[3]);
    return s;
  endfunction

  function automatic logic [3:0] exp_pins(logic [7:0] s);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = s[m_route[i*4 +: 3]];
    return p;
  endfunction

  task automatic compare_all();
    logic [7:0] s;
    s = exp_status();
    chk("R2 ab empty", status[0], s[0]);
    chk("R3 ab almost-empty", status[1], s[1]);
    chk("R5 ab full", status[2], s[2]);
    chk("R4 ab almost-full", status[3], s[3]);
    chk("R2 ba empty", status[4], s[4]);
    chk("R3 ba almost-empty", status[5], s[5]);
    chk("R5 ba full", status[6], s[6]);
    chk("R4 ba almost-full", status[7], s[7]);
    chk("R7 R8 pins", pins, exp_pins(s));
  endtask

  task automatic step(bit s_i, bit w_i, logic [2:0] a_i, logic [15:0] d_i,
                      int ca, int cb);
    @(negedge clk);
    sw = s_i; we = w_i; addr = a_i; wdata = d_i;
    cab = CNT_W'(ca); cba = CNT_W'(cb);
    @(posedge clk);
    if (s_i) begin
      for (int i = 0; i < 4; i++) m_ofs[i] = 0;
    end else if (w_i && a_i < 4) begin
      m_ofs[a_i] = int'(d_i[OFS_W-1:0]);
    end
    if (w_i && a_i == 3'd4) m_route = d_i;
    m_eab = (ca == 0); m_fab = (ca == DEPTH);
    m_eba = (cb == 0); m_fba = (cb == DEPTH);
    #2;
    compare_all();
  endtask

  function automatic int pick_cnt();
    int r = $urandom % 4;
    if (r == 0) return 0;
    if (r == 1) return DEPTH;
    return $urandom % (DEPTH + 1);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) m_ofs[i] = 0;
    m_route = 16'h3210;
    m_eab = 1; m_fab = 0; m_eba = 1; m_fba = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 status", status, 8'h33);
    chk("R1 pins", pins, 4'b0011);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    chk("R1 after release", status, 8'h33);

    // R6: upper bits ignored, offset takes effect next cycle
    step(0, 1, 3'd0, 16'hFC05, 5, 0);
    chk("R6 ab ae at offset", status[1], 1'b1);
    step(0, 0, 0, 0, 6, 0);
    chk("R6 ab ae above offset", status[1], 1'b0);
    // R2: empty lags by one cycle
    step(0, 0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 2, 3);
    chk("R2 empty lag", status[4], 1'b0);
    // R5: full reached
    step(0, 1, 3'd3, 16'h0002, 2, DEPTH);
    chk("R5 ba full", status[6], 1'b1);
    chk("R4 ba af", status[7], 1'b1);
    // R7: route with top bits set
    step(0, 1, 3'd4, 16'hF9E8, 2, DEPTH);
    chk("R7 ignored top bit", pins, exp_pins(exp_status()));
    // R9: clear wins over write, route unchanged
    step(1, 1, 3'd1, 16'h0007, 2, DEPTH);
    chk("R9 offsets cleared", status[1], 1'b0);
    chk("R9 route kept", m_route, 16'hF9E8);
    // R10: unused addresses
    step(0, 1, 3'd5, 16'h0123, 2, DEPTH);
    step(0, 1, 3'd6, 16'hFFFF, 2, DEPTH);
    step(0, 1, 3'd7, 16'h0000, 2, DEPTH);
    chk("R10 pins after idle writes", pins, exp_pins(exp_status()));

    for (int n = 0; n < 1500; n++) begin
      bit s_i, w_i;
      logic [2:0] a_i;
      logic [15:0] d_i;
      s_i = (($urandom % 40) == 0);
      w_i = (($urandom % 3) == 0);
      a_i = 3'($urandom % 8);
      d_i = 16'($urandom);
      if (a_i < 4) d_i[OFS_W-1:0] = OFS_W'($urandom % (DEPTH + 4));
      step(s_i, w_i, a_i, d_i, pick_cnt(), pick_cnt());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule